// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the packed-decimal time of a calendar counter and raises an alarm interrupt when the time agrees with values that software has programmed. The counter supplies seconds, minutes, hours, day of month, month and a three-digit year. It also supplies a strobe that pulses once per second, after the time has advanced.

Software programs the block through a small register port. The port holds a control word and six alarm value registers. Each bit of the control word enables the comparison of one field. A separate global bit gates the whole check. On a strobe with the global bit set, the alarm fires if any one enabled field equals its alarm value. Any single match is enough, because the field matches are ORed together.

A firing sets a pending flag and drives a level interrupt line. Both stay set until software writes one to the pending bit of the status register.

A two-state machine holds the interrupt:
- ST_IDLE means no alarm is pending.
- ST_FIRED means an alarm is pending.
- The transition named MATCH moves from ST_IDLE to ST_FIRED on a strobe with a hit.
- The transition named ACK moves from ST_FIRED to ST_IDLE on a clear write in a cycle with no firing.
- In every other case the state holds.

Top module: `rtcalm_top`

## Requirements
- R1: After reset the interrupt line is low, and every register address reads zero.
- R2: Each register stores its write data masked to its width and reads back that value. The widths are: address 0, control, 7 bits; address 1, seconds, 7 bits; address 2, minutes, 7 bits; address 3, hours, 6 bits; address 4, day, 6 bits; address 5, month, 5 bits; address 6, year, 12 bits.
- R3: While control bit 6 (global enable) is clear, no strobe raises the alarm, even when all fields match.
- R4: Control bits 0 to 5 enable the comparison of seconds, minutes, hours, day, month and year, in that order. A match on a disabled field never fires.
- R5: With the global enable set, a strobe fires when any single enabled field equals its alarm register (a logical OR). The month is compared as presented, which is 1-based packed decimal.
- R6: Comparison takes place only on a cycle with the strobe high. The interrupt rises on the clock edge that samples that strobe. A standing match without a strobe never fires.
- R7: The year comparison covers all 12 bits: hundreds in bits 11:8, tens and units in bits 7:0. A difference in the hundreds digit alone is a mismatch.
- R8: Address 7 is the status register. Its bit 1 reads the pending flag, and the interrupt line equals that flag.
- R9: A write to address 7 with bit 1 set clears the pending flag and the line on the next edge. A write to address 7 with bit 1 clear has no effect.
- R10: Once raised, the alarm stays asserted until it is cleared. Later strobes, whether or not they match, do not change it.
- R11: When a firing strobe and a clear write fall in the same cycle, the firing wins and the alarm stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_strobe | input | 1 | One-second pulse, high for one cycle after the time advances |
| tm_sec | input | 7 | Current seconds, packed decimal |
| tm_min | input | 7 | Current minutes, packed decimal |
| tm_hour | input | 6 | Current hours, packed decimal |
| tm_day | input | 6 | Current day of month, packed decimal |
| tm_mon | input | 5 | Current month, 1-based packed decimal |
| tm_year | input | 12 | Current three-digit year, packed decimal |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 to 7) |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational from addr |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
Two events can land on the same clock edge: a strobe that finds a match, and a software write that clears the pending bit. The bench provokes this by raising the strobe with a matching time in the same cycle that it drives the clear write to the status register. It then expects the line still high at the next sample, since a new event must not be lost. For contrast, it repeats the clear while a non-matching strobe is present, and there it expects the line to drop.

// File: rtl/rtcalm_pkg.sv
package rtcalm_pkg;
    localparam int NFLD     = 6;
    localparam int FW       = 12;
    localparam int CTL_W    = 7;
    localparam int ADDR_W   = 3;
    localparam int GLB_BIT  = 6;
    localparam int PEND_BIT = 1;

    localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FIRED = 1'b1
    } alm_state_e;

    function automatic logic [FW-1:0] fld_mask(input int idx);
        case (idx)
            0, 1:    fld_mask = 12'h07F;
            2, 3:    fld_mask = 12'h03F;
            4:       fld_mask = 12'h01F;
            default: fld_mask = 12'hFFF;
        endcase
    endfunction
endpackage

// File: rtl/rtcalm_regs.sv
module rtcalm_regs
    import rtcalm_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       pending,
    output logic [CTL_W-1:0]           ctl_q,
    output logic [NFLD-1:0][FW-1:0]    alm_q,
    output logic                       clr_req,
    output logic [DATA_W-1:0]          rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && addr == A_CTL) begin
            ctl_q <= wdata[CTL_W-1:0];
        end
    end

    for (genvar g = 0; g < NFLD; g++) begin : g_alm
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g + 1);
        localparam logic [FW-1:0]     MY_MASK = fld_mask(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alm_q[g] <= '0;
            end else if (wr_en && addr == MY_ADDR) begin
                alm_q[g] <= wdata[FW-1:0] & MY_MASK;
            end
        end
    end

    assign clr_req = wr_en && (addr == A_STAT) && wdata[PEND_BIT];

    always_comb begin
        rdata = '0;
        if (addr == A_CTL) begin
            rdata[CTL_W-1:0] = ctl_q;
        end else if (addr == A_STAT) begin
            rdata[PEND_BIT] = pending;
        end else begin
            for (int i = 0; i < NFLD; i++) begin
                if (addr == ADDR_W'(i + 1)) begin
                    rdata[FW-1:0] = alm_q[i];
                end
            end
        end
    end
endmodule

// File: rtl/rtcalm_match.sv
module rtcalm_match
    import rtcalm_pkg::*;
(
    input  logic [NFLD-1:0][FW-1:0] tm,
    input  logic [NFLD-1:0][FW-1:0] alm,
    input  logic [NFLD-1:0]         fld_en,
    input  logic                    glb_en,
    output logic                    hit
);
    logic [NFLD-1:0] eq;

    for (genvar g = 0; g < NFLD; g++) begin : g_cmp
        assign eq[g] = fld_en[g] && (tm[g] == alm[g]);
    end

    assign hit = glb_en && (|eq);
endmodule

// File: rtl/rtcalm_fsm.sv
module rtcalm_fsm
    import rtcalm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic irq,
    output logic pending
);
    alm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fire)          state_d = ST_FIRED;
            ST_FIRED: if (clr && !fire)  state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == ST_FIRED);
        irq     = pending;
    end
endmodule

// File: rtl/rtcalm_top.sv
module rtcalm_top
    import rtcalm_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_strobe,
    input  logic [6:0]        tm_sec,
    input  logic [6:0]        tm_min,
    input  logic [5:0]        tm_hour,
    input  logic [5:0]        tm_day,
    input  logic [4:0]        tm_mon,
    input  logic [11:0]       tm_year,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              alarm_irq
);
    logic [CTL_W-1:0]        ctl_q;
    logic [NFLD-1:0][FW-1:0] alm_q;
    logic [NFLD-1:0][FW-1:0] tm_vec;
    logic                    clr_req;
    logic                    alarm_hit;
    logic                    pend;

    assign tm_vec[0] = FW'(tm_sec);
    assign tm_vec[1] = FW'(tm_min);
    assign tm_vec[2] = FW'(tm_hour);
    assign tm_vec[3] = FW'(tm_day);
    assign tm_vec[4] = FW'(tm_mon);
    assign tm_vec[5] = tm_year;

    rtcalm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pending(pend), .ctl_q(ctl_q), .alm_q(alm_q), .clr_req(clr_req),
        .rdata(rdata)
    );

    rtcalm_match u_match (
        .tm(tm_vec), .alm(alm_q), .fld_en(ctl_q[NFLD-1:0]),
        .glb_en(ctl_q[GLB_BIT]), .hit(alarm_hit)
    );

    rtcalm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fire(sec_strobe && alarm_hit),
        .clr(clr_req), .irq(alarm_irq), .pending(pend)
    );
endmodule

// File: rtl/rtcalm_chk.sv
module rtcalm_chk (
    input logic clk,
    input logic rst_n,
    input logic strobe,
    input logic hit,
    input logic clr,
    input logic glb,
    input logic irq
);
    AST_NO_FIRE_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !strobe) |=> !irq); // R6
    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !glb) |=> !irq); // R3
    AST_STICKY_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq); // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(strobe && hit)) |=> !irq); // R9
    AST_FIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hit) |=> irq); // R11
endmodule

bind rtcalm_top rtcalm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(sec_strobe), .hit(alarm_hit),
    .clr(clr_req), .glb(ctl_q[6]), .irq(alarm_irq)
);

// File: tb/rtcalm_top_test.sv
module rtcalm_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_strobe = 1'b0;
    logic [6:0]  tm_sec = '0;
    logic [6:0]  tm_min = '0;
    logic [5:0]  tm_hour = '0;
    logic [5:0]  tm_day = '0;
    logic [4:0]  tm_mon = '0;
    logic [11:0] tm_year = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [11:0] wdata = '0;
    logic [11:0] rdata;
    logic        alarm_irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [11:0] av [6] = '{12'h045, 12'h037, 12'h021, 12'h015, 12'h012, 12'h321};
    logic [11:0] nv [6] = '{12'h010, 12'h011, 12'h005, 12'h003, 12'h007, 12'h320};

    always #2 clk = ~clk;

    rtcalm_top #(.DATA_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_day(tm_day),
        .tm_mon(tm_mon), .tm_year(tm_year), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .alarm_irq(alarm_irq)
    );

    function automatic logic [11:0] mask_of(input int a);
        case (a)
            0, 1, 2: mask_of = 12'h07F;
            3, 4:    mask_of = 12'h03F;
            5:       mask_of = 12'h01F;
            default: mask_of = 12'hFFF;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [11:0] d);
        @(negedge clk);
        addr = 3'(a);
        #1 d = rdata;
    endtask

    task automatic set_time(input int match_idx);
        logic [11:0] v [6];
        for (int k = 0; k < 6; k++) v[k] = (k == match_idx) ? av[k] : nv[k];
        tm_sec = v[0][6:0]; tm_min = v[1][6:0]; tm_hour = v[2][5:0];
        tm_day = v[3][5:0]; tm_mon = v[4][4:0]; tm_year = v[5];
    endtask

    task automatic set_all_match();
        tm_sec = av[0][6:0]; tm_min = av[1][6:0]; tm_hour = av[2][5:0];
        tm_day = av[3][5:0]; tm_mon = av[4][4:0]; tm_year = av[5];
    endtask

    task automatic pulse();
        @(negedge clk);
        sec_strobe = 1'b1;
        @(negedge clk);
        sec_strobe = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", alarm_irq, 0);
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk("R1 reg", d, 0);
        end

        // R2 masked storage sweep
        for (int a = 0; a < 7; a++) begin
            logic [11:0] pats [3] = '{12'hFFF, 12'hA5A, 12'h000};
            for (int p = 0; p < 3; p++) begin
                wr(a, pats[p]);
                rd(a, d);
                chk("R2 mask", d, pats[p] & mask_of(a));
            end
        end

        for (int k = 0; k < 6; k++) wr(k + 1, av[k]);

        // R4 R5 field enables x single-field matches
        for (int e = 0; e < 6; e++) begin
            wr(0, 12'h040 | (12'h1 << e));
            for (int j = 0; j < 6; j++) begin
                set_time(j);
                pulse();
                chk("R4/R5 field select", alarm_irq, (e == j) ? 1 : 0);
                wr(7, 12'h002);
            end
        end

        // R5 OR of several enabled fields, only one matching
        wr(0, 12'h07F);
        set_time(4);
        pulse();
        chk("R5 any-match month", alarm_irq, 1);
        wr(7, 12'h002);

        // R3 global off
        wr(0, 12'h03F);
        set_all_match();
        pulse();
        chk("R3 global gate", alarm_irq, 0);

        // R6 no strobe
        wr(0, 12'h07F);
        repeat (5) @(negedge clk);
        chk("R6 no strobe", alarm_irq, 0);
        @(negedge clk);
        sec_strobe = 1'b1;
        #1 chk("R6 before edge", alarm_irq, 0);
        @(negedge clk);
        sec_strobe = 1'b0;
        chk("R6 after edge", alarm_irq, 1);

        // R8 status read
        rd(7, d);
        chk("R8 pending bit", d, 12'h002);

        // R10 sticky over strobes
        set_time(-1);
        pulse();
        pulse();
        chk("R10 sticky", alarm_irq, 1);

        // R9 write without bit1 no effect
        wr(7, 12'hFFD);
        chk("R9 no clear", alarm_irq, 1);
        wr(7, 12'h002);
        chk("R9 clear", alarm_irq, 0);
        rd(7, d);
        chk("R9 status clear", d, 0);

        // R7 hundreds digit
        wr(0, 12'h060);
        tm_year = 12'h021;
        pulse();
        chk("R7 hundreds differ", alarm_irq, 0);
        tm_year = 12'h321;
        pulse();
        chk("R7 year match", alarm_irq, 1);

        // R11 fire and clear in same cycle
        @(negedge clk);
        sec_strobe = 1'b1; wr_en = 1'b1; addr = 3'd7; wdata = 12'h002;
        @(negedge clk);
        sec_strobe = 1'b0; wr_en = 1'b0;
        chk("R11 fire wins", alarm_irq, 1);
        tm_year = 12'h020;
        @(negedge clk);
        sec_strobe = 1'b1; wr_en = 1'b1; addr = 3'd7; wdata = 12'h002;
        @(negedge clk);
        sec_strobe = 1'b0; wr_en = 1'b0;
        chk("R11 clear with no match", alarm_irq, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule